// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block moves data words from a write clock domain to an unrelated read clock domain. It works in first-word-fall-through fashion: the oldest stored word is placed on the read data output without any request. A low output-ready flag tells the reader that this word is valid. The output register counts as one storage word, so a storage array of 2^k entries gives a total capacity of 2^k+1 words.

Both sides behave as active-low stream handshakes. On the write side, a low write enable is the valid and a low input-ready is the ready. A word moves on a rising write-clock edge only when both are low. When input-ready is high the producer is back-pressured and its words are dropped. On the read side, a low output-ready is the valid and a low read enable is the ready. The word on the output is consumed on a rising read-clock edge when both are low. It stays unchanged until then.

Pointers cross between the domains as Gray code through a chain of synchronizer flops. Input-ready, half-full and almost-full are computed in the write domain. Output-ready and almost-empty are computed in the read domain. All flags are active low. The almost-empty and almost-full offsets are parameters.

Top module: `dcfwft_fifo`

## Requirements
- R1: While reset is low and after its release with no traffic: output-ready is high, almost-empty is low, input-ready is low, half-full is high and almost-full is high.
- R2: A word on the write data input is stored on a rising write-clock edge when write enable is low and input-ready is low.
- R3: A word written into an empty FIFO appears on read data with output-ready low after two to four rising read-clock edges following the write edge. With the default of two synchronizer stages the nominal value is three edges, and one more is allowed when the two edges nearly coincide.
- R4: While output-ready is low and read enable is high, read data and output-ready hold. Words come out in write order. With read enable held low and words stored, a new word is presented after every rising read-clock edge.
- R5: When the last stored word is read, output-ready goes high and read data keeps that last word.
- R6: Total capacity is 2^DEPTH_LOG2+1 words, which is 9 by default. Input-ready goes high once that many words are held, and returns low after words are read.
- R7: A write attempted while input-ready is high is dropped: after draining, exactly the accepted words come out.
- R8: Almost-empty (offset AE_OFS, default 1) is low while AE_OFS+1 or fewer words are held and high at AE_OFS+2 or more, as seen in the read domain once the write pointer has crossed.
- R9: Half-full is low when the write-domain word count is at least (D-1)/2+2, where D is the total capacity. This is 6 for the defaults.
- R10: Almost-full (offset AF_OFS, default 2) is low when the write-domain word count is at least D-AF_OFS, which is 7 for the defaults.
- R11: The write pointer and both read pointers cross domains as Gray code, and each changes in at most one bit per edge of its own clock.
- R12: With unrelated clocks, simultaneous writing and reading, and back-pressure on both sides, every accepted word comes out once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low (producer valid) |
| wdata | input | DATA_W | Write data word |
| ir_n | output | 1 | Input-ready, low when a word can be accepted |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low (consumer ready) |
| rdata | output | DATA_W | Oldest word, valid while or_n is low |
| or_n | output | 1 | Output-ready, low when rdata holds a valid word |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
The properties assume that wen_n and ren_n are known and steady around their own clock's rising edge. They also assume that reset is applied to both domains together and released while no transfer is requested. The property that a word is held while unread depends on the read enable being the only way to consume it. The stimulus drives every input on the falling edge of its own clock and keeps both enables high through reset. Each side runs from its own clock with a period unrelated to the other, so the synchronizers see real phase drift.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  // Write-domain status bundle, all active low.
  typedef struct packed {
    logic ir_n;
    logic af_n;
    logic hf_n;
  } wr_flags_t;

endpackage

// File: rtl/fwft_cross.sv
// Gray-coded pointer crossing: registered Gray in the source domain,
// a chain of synchronizer flops in the destination, binary out.
module fwft_cross #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_bin_next,
  output logic [PW-1:0] src_gray,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);

  logic [STAGES:0][PW-1:0] chain;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_gray <= '0;
    else            src_gray <= src_bin_next ^ (src_bin_next >> 1);
  end

  assign chain[0] = src_gray;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) chain[s+1] <= '0;
      else            chain[s+1] <= chain[s];
    end
  end

  always_comb begin
    logic [PW-1:0] acc;
    acc[PW-1] = chain[STAGES][PW-1];
    for (int i = PW - 2; i >= 0; i--) acc[i] = acc[i+1] ^ chain[STAGES][i];
    dst_bin = acc;
  end

endmodule

// File: rtl/fwft_mem.sv
// Storage array: synchronous write, asynchronous read.
module fwft_mem #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] store [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/fwft_wr_ctl.sv
// Write-domain control: pointer, acceptance and write-side flags.
module fwft_wr_ctl
  import fwft_pkg::*;
#(
  parameter int AW    = 3,
  parameter int PW    = 5,
  parameter int D     = 9,
  parameter int AF_TH = 7,
  parameter int HF_TH = 6
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic [PW-1:0] rfetch_w,
  input  logic [PW-1:0] rpop_w,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr_next,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] count,
  output wr_flags_t     flags
);

  localparam logic [PW-1:0] ARR_P = PW'(1 << AW);
  localparam logic [PW-1:0] D_P   = PW'(D);
  localparam logic [PW-1:0] AF_P  = PW'(AF_TH);
  localparam logic [PW-1:0] HF_P  = PW'(HF_TH);

  logic [PW-1:0] arr_cnt;
  logic          full;

  assign arr_cnt   = wptr - rfetch_w;
  assign count     = wptr - rpop_w;
  assign full      = (arr_cnt == ARR_P) || (count >= D_P);
  assign we        = !wen_n && !full;
  assign wptr_next = wptr + PW'(we);
  assign waddr     = wptr[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else        wptr <= wptr_next;
  end

  assign flags.ir_n = full;
  assign flags.af_n = !(count >= AF_P);
  assign flags.hf_n = !(count >= HF_P);

endmodule

// File: rtl/fwft_rd_ctl.sv
// Read-domain control: fall-through output register and read-side flags.
module fwft_rd_ctl #(
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int PW    = 5,
  parameter int AE_TH = 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic [PW-1:0] wptr_r,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rfetch_next,
  output logic [PW-1:0] rpop_next,
  output logic [DW-1:0] rdata,
  output logic          or_n,
  output logic          ae_n
);

  localparam logic [PW-1:0] AE_P = PW'(AE_TH);

  logic [PW-1:0] rfetch_q, rpop_q, rtotal;
  logic          ovalid_q, avail, pop, fetch;

  assign avail       = (wptr_r != rfetch_q);
  assign pop         = ovalid_q && !ren_n;
  assign fetch       = avail && (!ovalid_q || pop);
  assign rfetch_next = rfetch_q + PW'(fetch);
  assign rpop_next   = rpop_q + PW'(pop);
  assign raddr       = rfetch_q[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rfetch_q <= '0;
      rpop_q   <= '0;
      ovalid_q <= 1'b0;
      rdata    <= '0;
    end else begin
      rfetch_q <= rfetch_next;
      rpop_q   <= rpop_next;
      ovalid_q <= fetch || (ovalid_q && !pop);
      if (fetch) rdata <= mem_rdata;
    end
  end

  assign rtotal = wptr_r - rpop_q;
  assign or_n   = !ovalid_q;
  assign ae_n   = (rtotal > AE_P);

endmodule

// File: rtl/dcfwft_fifo.sv
// Dual-clock first-word-fall-through FIFO, top level.
module dcfwft_fifo #(
  parameter int DATA_W      = 16,
  parameter int DEPTH_LOG2  = 3,
  parameter int AE_OFS      = 1,
  parameter int AF_OFS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              ir_n,
  output logic              af_n,
  output logic              hf_n,
  input  logic              rclk,
  input  logic              ren_n,
  output logic [DATA_W-1:0] rdata,
  output logic              or_n,
  output logic              ae_n
);

  localparam int PW      = DEPTH_LOG2 + 2;
  localparam int TOTAL_D = (1 << DEPTH_LOG2) + 1;
  localparam int HF_TH   = (TOTAL_D - 1) / 2 + 2;
  localparam int AF_TH   = TOTAL_D - AF_OFS;
  localparam int AE_TH   = AE_OFS + 1;

  logic                  we;
  logic [DEPTH_LOG2-1:0] waddr, raddr;
  logic [DATA_W-1:0]     mem_rdata;
  logic [PW-1:0]         wptr_next, wptr_w, count_w, wgray, wptr_r;
  logic [PW-1:0]         rfetch_next, rpop_next, rfetch_gray, rpop_gray;
  logic [PW-1:0]         rfetch_w, rpop_w;
  fwft_pkg::wr_flags_t   wflags;

  fwft_mem #(.DW(DATA_W), .AW(DEPTH_LOG2)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(mem_rdata)
  );

  fwft_wr_ctl #(
    .AW(DEPTH_LOG2), .PW(PW), .D(TOTAL_D), .AF_TH(AF_TH), .HF_TH(HF_TH)
  ) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n),
    .rfetch_w(rfetch_w), .rpop_w(rpop_w),
    .we(we), .waddr(waddr), .wptr_next(wptr_next), .wptr(wptr_w),
    .count(count_w), .flags(wflags)
  );

  fwft_rd_ctl #(
    .DW(DATA_W), .AW(DEPTH_LOG2), .PW(PW), .AE_TH(AE_TH)
  ) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wptr_r(wptr_r),
    .mem_rdata(mem_rdata), .raddr(raddr),
    .rfetch_next(rfetch_next), .rpop_next(rpop_next),
    .rdata(rdata), .or_n(or_n), .ae_n(ae_n)
  );

  fwft_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_wptr (
    .src_clk(wclk), .src_rst_n(rst_n), .src_bin_next(wptr_next),
    .src_gray(wgray), .dst_clk(rclk), .dst_rst_n(rst_n), .dst_bin(wptr_r)
  );

  fwft_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_rfetch (
    .src_clk(rclk), .src_rst_n(rst_n), .src_bin_next(rfetch_next),
    .src_gray(rfetch_gray), .dst_clk(wclk), .dst_rst_n(rst_n), .dst_bin(rfetch_w)
  );

  fwft_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_rpop (
    .src_clk(rclk), .src_rst_n(rst_n), .src_bin_next(rpop_next),
    .src_gray(rpop_gray), .dst_clk(wclk), .dst_rst_n(rst_n), .dst_bin(rpop_w)
  );

  assign ir_n = wflags.ir_n;
  assign af_n = wflags.af_n;
  assign hf_n = wflags.hf_n;

endmodule

// File: rtl/fwft_checker.sv
module fwft_checker #(
  parameter int DW = 16,
  parameter int PW = 5,
  parameter int D  = 9
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          wen_n,
  input logic          ren_n,
  input logic          ir_n,
  input logic          af_n,
  input logic          hf_n,
  input logic          or_n,
  input logic [DW-1:0] rdata,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] count_w,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rfetch_gray,
  input logic [PW-1:0] rpop_gray
);

  assert_wgray_step_R11: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rfetch_gray_step_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rfetch_gray ^ $past(rfetch_gray)) <= 1);

  assert_rpop_gray_step_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rpop_gray ^ $past(rpop_gray)) <= 1);

  assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    count_w <= PW'(D));

  assert_blocked_write_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wen_n && ir_n) |=> (wptr == $past(wptr)));

  assert_hold_unread_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!or_n && ren_n) |=> (!or_n && $stable(rdata)));

  assert_last_word_kept_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(or_n) |-> $stable(rdata));

  assert_af_implies_hf_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    !af_n |-> !hf_n);

  assert_full_implies_af_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    ir_n |-> !af_n);

endmodule

bind dcfwft_fifo fwft_checker #(.DW(DATA_W), .PW(PW), .D(TOTAL_D)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .wen_n(wen_n), .ren_n(ren_n),
  .ir_n(ir_n), .af_n(af_n), .hf_n(hf_n), .or_n(or_n), .rdata(rdata),
  .wptr(wptr_w), .count_w(count_w), .wgray(wgray),
  .rfetch_gray(rfetch_gray), .rpop_gray(rpop_gray)
);

// File: tb/dcfwft_fifo_test.sv
`timescale 1ns/1ps
module dcfwft_fifo_test;

  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW     = 16;
  localparam int D      = 9;
  localparam int AE_TH  = 2;
  localparam int HF_TH  = 6;
  localparam int AF_TH  = 7;
  localparam int STREAM = 120;

  logic rst_n, wclk, rclk, wen_n, ren_n;
  logic [DW-1:0] wdata;
  logic ir_n, af_n, hf_n, or_n, ae_n;
  logic [DW-1:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] model [$];

  dcfwft_fifo uut (
    .rst_n(rst_n), .wclk(wclk), .wen_n(wen_n), .wdata(wdata),
    .ir_n(ir_n), .af_n(af_n), .hf_n(hf_n),
    .rclk(rclk), .ren_n(ren_n), .rdata(rdata), .or_n(or_n), .ae_n(ae_n)
  );

  initial begin wclk = 0; forever #(CLK_PERIOD/2) wclk = ~wclk; end
  initial begin rclk = 0; forever #(RCLK_PERIOD/2) rclk = ~rclk; end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic settle;
    repeat (5) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  // Single write attempt on the next write edge; returns whether accepted.
  task automatic write_one(input logic [DW-1:0] v, output bit taken);
    @(negedge wclk);
    taken = !ir_n;
    wen_n = 1'b0;
    wdata = v;
    if (taken) model.push_back(v);
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; wdata = '0;
    repeat (3) @(negedge wclk);
    check(or_n == 1'b1, "R1", "or_n in reset", int'(or_n), 1);
    check(ae_n == 1'b0, "R1", "ae_n in reset", int'(ae_n), 0);
    check(ir_n == 1'b0, "R1", "ir_n in reset", int'(ir_n), 0);
    rst_n = 1'b1;
    settle();
    check({or_n, ae_n, ir_n, hf_n, af_n} == 5'b10011, "R1", "flags after release",
          int'({or_n, ae_n, ir_n, hf_n, af_n}), 5'b10011);
  endtask

  task automatic t_fall_through;
    int edges = 0;
    logic [DW-1:0] v = 16'h5A11;
    @(negedge wclk);
    wen_n = 1'b0; wdata = v; model.push_back(v);
    @(posedge wclk);
    #1 wen_n = 1'b1;
    while (or_n && edges < 8) begin
      @(posedge rclk);
      edges++;
      #1;
    end
    check(edges >= 2 && edges <= 4, "R3", "first word latency in read edges", edges, 3);
    check(rdata == v, "R2", "fall-through data", int'(rdata), int'(v));
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk);
      check(!or_n && rdata == v, "R4", "unread word held", int'(rdata), int'(v));
    end
    ren_n = 1'b0;
    void'(model.pop_front());
    @(negedge rclk);
    ren_n = 1'b1;
    check(or_n == 1'b1, "R5", "or_n after last read", int'(or_n), 1);
    check(rdata == v, "R5", "last word kept", int'(rdata), int'(v));
  endtask

  task automatic t_fill_and_drain;
    bit taken;
    logic [DW-1:0] last;
    for (int k = 1; k <= D; k++) begin
      write_one(DW'(16'hA000 + k), taken);
      check(taken, "R2", "write accepted while ready", int'(taken), 1);
      settle();
      check(hf_n == !(k >= HF_TH), "R9", $sformatf("hf_n at %0d words", k), int'(hf_n), int'(!(k >= HF_TH)));
      check(af_n == !(k >= AF_TH), "R10", $sformatf("af_n at %0d words", k), int'(af_n), int'(!(k >= AF_TH)));
      check(ir_n == (k >= D), "R6", $sformatf("ir_n at %0d words", k), int'(ir_n), int'(k >= D));
      check(ae_n == (k > AE_TH), "R8", $sformatf("ae_n at %0d words", k), int'(ae_n), int'(k > AE_TH));
    end
    write_one(16'hDEAD, taken);
    check(!taken, "R7", "ready flag high on extra write", int'(taken), 0);
    settle();
    check(ir_n == 1'b1, "R6", "ir_n stays high while full", int'(ir_n), 1);
    // Drain with read enable held low: one word per read edge.
    @(negedge rclk);
    ren_n = 1'b0;
    for (int i = 0; i < D; i++) begin
      logic [DW-1:0] exp_v = model.pop_front();
      check(!or_n && rdata == exp_v, "R4", $sformatf("drain word %0d", i), int'(rdata), int'(exp_v));
      last = exp_v;
      @(negedge rclk);
    end
    ren_n = 1'b1;
    check(or_n == 1'b1, "R7", "no extra word after drain", int'(or_n), 1);
    settle();
    check(or_n == 1'b1 && rdata == last, "R5", "last word kept after drain", int'(rdata), int'(last));
    check(ir_n == 1'b0, "R6", "ir_n low after reads", int'(ir_n), 0);
    check(ae_n == 1'b0, "R8", "ae_n low when empty", int'(ae_n), 0);
  endtask

  task automatic t_stream;
    int bad = 0;
    int got = 0;
    fork
      begin : wr_side
        int sent = 0;
        int cyc  = 0;
        while (sent < STREAM) begin
          @(negedge wclk);
          cyc++;
          if ((cyc % 5 != 2) && !ir_n) begin
            wen_n = 1'b0;
            wdata = DW'(16'h3000 + sent);
            model.push_back(wdata);
            sent++;
          end else begin
            wen_n = 1'b1;
          end
        end
        @(negedge wclk);
        wen_n = 1'b1;
      end
      begin : rd_side
        int cyc = 0;
        while (got < STREAM) begin
          @(negedge rclk);
          cyc++;
          if (!or_n && (cyc < 80 ? (cyc % 4 == 0) : (cyc % 3 != 1))) begin
            if (model.size() == 0 || rdata != model[0]) begin
              bad++;
              if (bad == 1)
                $display("FAIL R12 stream word %0d: actual %0d expected %0d", got,
                         rdata, model.size() ? model[0] : 0);
            end
            if (model.size() != 0) void'(model.pop_front());
            ren_n = 1'b0;
            got++;
          end else begin
            ren_n = 1'b1;
          end
        end
        @(negedge rclk);
        ren_n = 1'b1;
      end
    join
    n_checks++;
    if (bad != 0) n_fail++;
    settle();
    check(got == STREAM && model.size() == 0, "R12", "stream words out", got, STREAM);
    check(or_n == 1'b1, "R12", "empty after stream", int'(or_n), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_fall_through();
    t_fill_and_drain();
    t_stream();
    summary();
    $finish;
  end

endmodule